// File: doc/BRIEF.md
# Three-Read One-Write Register Bank with Write Forwarding

This block is the integer register bank of a small processor core. It has one write port and three read ports. Each read port takes a 4-bit selector and returns a 64-bit word with no clock delay, so the decode stage can fetch up to three operands in the same cycle. Writes are stored on the rising clock edge.

Selector 15 is a constant-zero register. No storage exists behind it. Any write aimed at selector 15 is dropped. Selectors 0 to 14 are real storage words, and a synchronous reset clears all of them.

A read can target the word that is being written in the same cycle. In that case the read port returns the incoming write data rather than the old stored value. A write-back stage can therefore complete in the same cycle that a dependent instruction reads its operands. Each read port settles its result in a fixed order:
1. The constant-zero selector wins.
2. Otherwise, same-cycle write data wins.
3. Otherwise, the port returns the stored word.

Top module: `tri_read_regbank`

## Requirements
- R1: While `rst` is high at a rising edge, all 15 stored words become zero, so every selector reads zero after reset until it is written.
- R2: When `wr_en` is high at a rising edge and `wr_sel` is 0 to 14, the word at `wr_sel` takes `wr_data`. Later reads of that selector return the value until it is overwritten.
- R3: A read port whose selector is 15 (all ones) outputs all zeros in every cycle, whatever the write port is doing.
- R4: When `wr_en` is high, `wr_sel` is 0 to 14 and a read selector equals `wr_sel`, that read port outputs `wr_data` combinationally in the same cycle.
- R5: A write with `wr_sel` = 15 changes no stored word and is never forwarded to any read port.
- R6: When `wr_en` is low, no stored word changes and no read port forwards `wr_data`, even if a read selector equals `wr_sel`.
- R7: The three read ports are independent. Any mix of selectors, including all three equal, gives each port its own correct value.
- R8: Each read port resolves its result in fixed priority: constant-zero selector first, then same-cycle forwarding, then the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the stored words |
| wr_en | input | 1 | Write request for this cycle |
| wr_sel | input | 4 | Word written; 15 is dropped |
| wr_data | input | 64 | Data to store and to forward |
| rd_sel_a | input | 4 | Selector of read port A |
| rd_sel_b | input | 4 | Selector of read port B |
| rd_sel_c | input | 4 | Selector of read port C |
| rd_data_a | output | 64 | Read port A result |
| rd_data_b | output | 64 | Read port B result |
| rd_data_c | output | 64 | Read port C result |

## Verification
A corrupted stored word stays hidden until some read port selects it. After that, the wrong value appears on that port in the same cycle, so the bench compares all three ports against a behavioural model every cycle, with selectors spread over all 16 codes.

The forwarding path has different failure modes, and they show at once:
- A missing forward shows as a stale value in the cycle of the write.
- A forward that fires wrongly (with enable low, or on selector 15) shows as write data leaking out.
- A write that lands when it should not shows one cycle later, as a changed word.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int RB_DATA_W = 64;
  localparam int RB_SEL_W  = 4;
  localparam int RB_RD_PORTS = 3;
endpackage

// File: rtl/regbank_store.sv
module regbank_store #(
  parameter int DATA_W = 64,
  parameter int SEL_W  = 4,
  parameter int NRD    = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [SEL_W-1:0]            wr_sel,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic [NRD-1:0][SEL_W-1:0]   rd_sel,
  output logic [NRD-1:0][DATA_W-1:0]  rd_word
);
  localparam int DEPTH = (2 ** SEL_W) - 1;
  localparam logic [SEL_W-1:0] ZERO_SEL = {SEL_W{1'b1}};

  logic [DATA_W-1:0] mem [DEPTH];

  // Writes to the constant-zero selector have nowhere to land and are dropped.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else if (wr_en && (wr_sel != ZERO_SEL)) begin
      mem[wr_sel] <= wr_data;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_word[p] = (rd_sel[p] != ZERO_SEL) ? mem[rd_sel[p]] : '0;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_chk
    AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (mem[i] == '0));                                  // R1
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_sel == SEL_W'(i)) |=> (mem[i] == $past(wr_data))); // R2
    AST_WORD_HELD: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && wr_sel == SEL_W'(i)) |=> $stable(mem[i]));     // R6
  end
endmodule

// File: rtl/regbank_rd_port.sv
module regbank_rd_port #(
  parameter int DATA_W = 64,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  input  logic [DATA_W-1:0] stored_word,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [SEL_W-1:0] ZERO_SEL = {SEL_W{1'b1}};

  logic is_zero;
  logic fwd_hit;

  assign is_zero = (rd_sel == ZERO_SEL);
  assign fwd_hit = wr_en && (wr_sel == rd_sel);

  // Priority: constant zero, then same-cycle write data, then storage.
  always_comb begin
    if (is_zero)      rd_data = '0;
    else if (fwd_hit) rd_data = wr_data;
    else              rd_data = stored_word;
  end

  AST_ZERO_TOP: assert property (@(posedge clk) disable iff (rst)
    (rd_sel == ZERO_SEL) |-> (rd_data == '0));                  // R3
  AST_FWD_SAME_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rd_sel == wr_sel && rd_sel != ZERO_SEL) |-> (rd_data == wr_data)); // R4
  AST_ZERO_WR_DROP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == ZERO_SEL && rd_sel == ZERO_SEL) |-> (rd_data == '0)); // R5
  AST_NO_FWD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && rd_sel != ZERO_SEL) |-> (rd_data == stored_word)); // R6
endmodule

// File: rtl/tri_read_regbank.sv
module tri_read_regbank
  import regbank_pkg::*;
#(
  parameter int DATA_W = RB_DATA_W,
  parameter int SEL_W  = RB_SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_sel_a,
  input  logic [SEL_W-1:0]  rd_sel_b,
  input  logic [SEL_W-1:0]  rd_sel_c,
  output logic [DATA_W-1:0] rd_data_a,
  output logic [DATA_W-1:0] rd_data_b,
  output logic [DATA_W-1:0] rd_data_c
);
  localparam int NRD = RB_RD_PORTS;

  logic [NRD-1:0][SEL_W-1:0]  sel_v;
  logic [NRD-1:0][DATA_W-1:0] word_v;
  logic [NRD-1:0][DATA_W-1:0] data_v;

  assign sel_v[0] = rd_sel_a;
  assign sel_v[1] = rd_sel_b;
  assign sel_v[2] = rd_sel_c;

  regbank_store #(.DATA_W(DATA_W), .SEL_W(SEL_W), .NRD(NRD)) store_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(sel_v), .rd_word(word_v)
  );

  for (genvar p = 0; p < NRD; p++) begin : g_port
    regbank_rd_port #(.DATA_W(DATA_W), .SEL_W(SEL_W)) port_i (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_sel(sel_v[p]), .stored_word(word_v[p]), .rd_data(data_v[p])
    );
  end

  assign rd_data_a = data_v[0];
  assign rd_data_b = data_v[1];
  assign rd_data_c = data_v[2];

  AST_SAME_SEL_AGREE: assert property (@(posedge clk) disable iff (rst)
    (rd_sel_a == rd_sel_b && rd_sel_b == rd_sel_c) |->
      (rd_data_a == rd_data_b && rd_data_b == rd_data_c));      // R7
endmodule

// File: tb/tri_read_regbank_tb.sv
module tri_read_regbank_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_sel = '0;
  logic [63:0] wr_data = '0;
  logic [3:0]  rd_sel_a = '0, rd_sel_b = '0, rd_sel_c = '0;
  logic [63:0] rd_data_a, rd_data_b, rd_data_c;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [63:0] model [15];

  always #5 clk = ~clk;

  tri_read_regbank dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel_a(rd_sel_a), .rd_sel_b(rd_sel_b), .rd_sel_c(rd_sel_c),
    .rd_data_a(rd_data_a), .rd_data_b(rd_data_b), .rd_data_c(rd_data_c)
  );

  function automatic logic [63:0] expect_rd(input logic [3:0] s);
    if (s == 4'd15) return 64'd0;
    if (wr_en && s == wr_sel) return wr_data;
    return model[s];
  endfunction

  task automatic check(input string tag, input string port, input logic [63:0] got,
                       input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s port %s: got %h expected %h", tag, port, got, exp);
    end
  endtask

  // Drive one cycle at the falling edge, compare all ports, then advance the model
  // to the state the next rising edge produces.
  task automatic step(input string tag, input bit r, input bit we, input logic [3:0] ws,
                      input logic [63:0] wd, input logic [3:0] a, input logic [3:0] b,
                      input logic [3:0] c, input bit do_chk);
    @(negedge clk);
    rst = r; wr_en = we; wr_sel = ws; wr_data = wd;
    rd_sel_a = a; rd_sel_b = b; rd_sel_c = c;
    #2;
    if (do_chk) begin
      check(tag, "A", rd_data_a, expect_rd(a));
      check(tag, "B", rd_data_b, expect_rd(b));
      check(tag, "C", rd_data_c, expect_rd(c));
    end
    if (r) begin
      for (int k = 0; k < 15; k++) model[k] = 64'd0;
    end else if (we && ws != 4'd15) begin
      model[ws] = wd;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 15; k++) model[k] = 64'd0;
    step("reset", 1, 0, 0, 0, 0, 1, 2, 0);
    step("reset", 1, 0, 0, 0, 3, 4, 5, 0);
    // R1: every selector reads zero after reset
    for (int s = 0; s < 16; s += 3)
      step("R1", 0, 0, 0, 0, 4'(s), 4'(s + 1), 4'(s + 2), 1);
    // R2: fill words, then read them back
    for (int s = 0; s < 15; s++)
      step("R2", 0, 1, 4'(s), {32'hA5A5_0000, 32'(s * 7 + 1)}, 4'd15, 4'd15, 4'd15, 1);
    for (int s = 0; s < 15; s += 3)
      step("R2", 0, 0, 0, 0, 4'(s), 4'(s + 1), 4'(s + 2), 1);
    // R4: same-cycle forwarding on each port
    step("R4", 0, 1, 4'd5, 64'hDEAD_BEEF_0000_0005, 4'd5, 4'd6, 4'd7, 1);
    step("R4", 0, 1, 4'd6, 64'h1234_5678_9ABC_DEF0, 4'd0, 4'd6, 4'd7, 1);
    step("R4", 0, 1, 4'd14, 64'hFFFF_FFFF_FFFF_FFFF, 4'd1, 4'd2, 4'd14, 1);
    step("R2", 0, 0, 0, 0, 4'd5, 4'd6, 4'd14, 1);
    // R3/R5: write to selector 15 neither forwards nor stores
    step("R5", 0, 1, 4'd15, 64'hCAFE_CAFE_CAFE_CAFE, 4'd15, 4'd15, 4'd15, 1);
    step("R3", 0, 1, 4'd15, 64'h0123_4567_89AB_CDEF, 4'd15, 4'd0, 4'd15, 1);
    step("R5", 0, 0, 0, 0, 4'd0, 4'd1, 4'd13, 1);
    // R6: enable low with matching selector: no forward, no update
    step("R6", 0, 0, 4'd3, 64'h5555_5555_5555_5555, 4'd3, 4'd3, 4'd4, 1);
    step("R6", 0, 0, 4'd3, 64'h0, 4'd3, 4'd2, 4'd4, 1);
    // R7: same selector on all three ports, stored and forwarded
    step("R7", 0, 0, 0, 0, 4'd9, 4'd9, 4'd9, 1);
    step("R7", 0, 1, 4'd9, 64'h9999_0000_9999_0000, 4'd9, 4'd9, 4'd9, 1);
    step("R7", 0, 0, 0, 0, 4'd9, 4'd9, 4'd9, 1);
    // R8: mixed random traffic over all selectors
    for (int n = 0; n < 400; n++)
      step("R8", 0, 1'($urandom_range(0, 1)), 4'($urandom_range(0, 15)),
           {$urandom, $urandom}, 4'($urandom_range(0, 15)),
           4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)), 1);
    // R1: reset in mid-run clears stored words
    step("R1", 1, 1, 4'd2, 64'h7777, 0, 1, 2, 0);
    step("R1", 0, 0, 0, 0, 4'd2, 4'd8, 4'd14, 1);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule